// File: doc/BRIEF.md
# Carry-Save Transposed FIR Filter

This block is a 14-tap finite impulse response filter for 8-bit signed samples with 8-bit signed coefficients. It is built in transposed form. Every accepted sample is registered once and then presented to all taps at the same time. Each tap forms the product of that sample with its own coefficient. The sample is radix-4 Booth recoded once, and each tap then picks its partial products with a small multiplexer and reduces them to a sum/carry pair. The tap folds that pair into the running pair passed on by the previous tap, using a 4:2 carry-save compression. No carry is propagated anywhere in the chain. Only the last tap's pair reaches a two-stage split adder. The lower half of that adder produces a carry, and the upper half has both outcomes precomputed, so the carry only has to pick one. The adder delivers a 20-bit two's complement result.

The input stream is one optional sample per cycle. A cycle with the valid flag low counts as a zero sample. A valid flag rides a delay line beside the data. An output valid appears exactly 19 cycles after each input valid, which is the depth of the path from the head tap to the output. The result shown with it is the full 14-term window that starts at that sample: the coefficient of index k is applied to the sample accepted 13−k cycles after the tagged one.

Coefficients are written one at a time through an indexed load port. A write takes effect for the sample presented in the same cycle and for every later sample. Samples already in flight keep the value they were multiplied with.

Top module: `csa_fir`

## Requirements
- R1: While reset is held and on the first cycle after it, the output valid is 0 and the result is 0. All coefficients reset to 0, so samples streamed before any load produce results of 0.
- R2: Each cycle with `inValid` high gives exactly one cycle with `outValid` high, 19 clock edges later. `outValid` is never high at any other time.
- R3: Let x(t) be the sample accepted at edge t, or 0 if none was accepted. Let c_k be the coefficient with index k that was in force for that sample. The result shown with the output valid of the sample at edge m is the sum, over k = 0..13, of c_k · x(m+13−k).
- R4: Samples and coefficients are 8-bit two's complement. The result is the exact 20-bit two's complement sum, including the extreme case where every operand is −128.
- R5: Writing a coefficient (`coefWe` high, `coefIdx` in 0..13, value on `coefData`) changes it for the sample presented in the same cycle and for all later samples. Samples presented earlier are not affected.
- R6: A write with `coefIdx` of 14 or 15 changes no coefficient.
- R7: In a cycle with `inValid` low, the value on `sampleIn` is ignored and that cycle counts as a zero sample.
- R8: After 19 or more consecutive cycles with `inValid` low, the result is 0.
- R9: Valid samples can be presented on every cycle without a gap, and each one gets its own result, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The sample on `sampleIn` is accepted this cycle |
| sampleIn | input | 8 | Signed input sample |
| coefWe | input | 1 | Coefficient write strobe |
| coefIdx | input | 4 | Index of the coefficient to write; 0..13 are valid |
| coefData | input | 8 | Signed coefficient value |
| outValid | output | 1 | The result is valid this cycle |
| result | output | 20 | Signed filter result |

## Verification
A coefficient write and a valid sample can arrive in the same cycle. The filter must then apply the new value to that very sample, while every product already in the tap chain keeps the old value. The bench provokes this by streaming samples without a gap while it writes random coefficients on about half of those cycles, and also by mixing in writes to the two out-of-range indices. The reference model keeps a copy of the coefficient set for each sample cycle, and each result is compared against the window built from those copies. A design that applies a write one cycle early or one cycle late, or that lets an out-of-range write change a tap, therefore gives a wrong sum.

// File: rtl/csa_fir_pkg.sv
package csa_fir_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleTake;   // capture the sample, otherwise inject zero
    logic coefLoad;     // a write with an in-range index
  } fir_ctrl_t;

  // One radix-4 Booth digit: value is (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

endpackage

// File: rtl/csa_fir_ctrl.sv
module csa_fir_ctrl
  import csa_fir_pkg::*;
#(
  parameter int TAPS  = 14,
  parameter int LAT   = 19,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             coefWe,
  input  logic [IDX_W-1:0] coefIdx,
  output fir_ctrl_t        strobes,
  output logic             outValid
);

  logic [LAT-1:0] validLine;

  always_comb begin
    strobes.sampleTake = inValid;
    strobes.coefLoad   = coefWe && ({1'b0, coefIdx} < (IDX_W+1)'(TAPS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validLine <= '0;
    else       validLine <= {validLine[LAT-2:0], inValid};
  end

  assign outValid = validLine[LAT-1];

endmodule

// File: rtl/csa_fir_tap.sv
module csa_fir_tap
  import csa_fir_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20,
  parameter int NDIG   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   coefWe,
  input  logic [COEF_W-1:0]      coefData,
  input  booth_dig_t [NDIG-1:0]  booth,
  input  logic [ACC_W-1:0]       chainSumIn,
  input  logic [ACC_W-1:0]       chainCarryIn,
  output logic [ACC_W-1:0]       chainSumOut,
  output logic [ACC_W-1:0]       chainCarryOut
);

  logic [COEF_W-1:0]       coefReg;
  logic signed [ACC_W-1:0] coefWide;
  logic [ACC_W-1:0]        redSum   [NDIG-1];
  logic [ACC_W-1:0]        redCarry [NDIG-1];
  logic [ACC_W-1:0]        mulSum, mulCarry;
  logic [ACC_W-1:0]        midSum, midCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       coefReg <= '0;
    else if (coefWe) coefReg <= coefData;
  end

  assign coefWide = {{(ACC_W-COEF_W){coefReg[COEF_W-1]}}, coefReg};

  // Booth multiplexer per digit, one register stage
  for (genvar d = 0; d < NDIG; d++) begin : g_pp
    logic signed [ACC_W-1:0] mag;
    logic [ACC_W-1:0]        ppReg;
    always_comb begin
      if (booth[d].two)      mag = coefWide <<< 1;
      else if (booth[d].one) mag = coefWide;
      else                   mag = '0;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ppReg <= '0;
      else       ppReg <= (booth[d].neg ? -mag : mag) <<< (2*d);
    end
  end

  // Linear carry-save reduction of the partial products
  assign redSum[0]   = g_pp[0].ppReg;
  assign redCarry[0] = g_pp[1].ppReg;
  for (genvar i = 1; i < NDIG-1; i++) begin : g_red
    assign redSum[i]   = redSum[i-1] ^ redCarry[i-1] ^ g_pp[i+1].ppReg;
    assign redCarry[i] = ((redSum[i-1] & redCarry[i-1]) |
                          (redSum[i-1] & g_pp[i+1].ppReg) |
                          (redCarry[i-1] & g_pp[i+1].ppReg)) << 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulSum   <= '0;
      mulCarry <= '0;
    end else begin
      mulSum   <= redSum[NDIG-2];
      mulCarry <= redCarry[NDIG-2];
    end
  end

  // 4:2 compression of incoming chain pair with own product pair
  assign midSum   = chainSumIn ^ chainCarryIn ^ mulSum;
  assign midCarry = ((chainSumIn & chainCarryIn) | (chainSumIn & mulSum) |
                     (chainCarryIn & mulSum)) << 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainSumOut   <= '0;
      chainCarryOut <= '0;
    end else begin
      chainSumOut   <= midSum ^ midCarry ^ mulCarry;
      chainCarryOut <= ((midSum & midCarry) | (midSum & mulCarry) |
                        (midCarry & mulCarry)) << 1;
    end
  end

endmodule

// File: rtl/csa_fir_final_add.sv
module csa_fir_final_add #(
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] sumVec,
  input  logic [ACC_W-1:0] carryVec,
  output logic [ACC_W-1:0] total
);

  localparam int LO_W = ACC_W / 2;
  localparam int HI_W = ACC_W - LO_W;

  logic [LO_W:0]   loReg;
  logic [HI_W-1:0] hiNoCarry, hiWithCarry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loReg       <= '0;
      hiNoCarry   <= '0;
      hiWithCarry <= '0;
      total       <= '0;
    end else begin
      loReg       <= {1'b0, sumVec[LO_W-1:0]} + {1'b0, carryVec[LO_W-1:0]};
      hiNoCarry   <= sumVec[ACC_W-1:LO_W] + carryVec[ACC_W-1:LO_W];
      hiWithCarry <= sumVec[ACC_W-1:LO_W] + carryVec[ACC_W-1:LO_W] + HI_W'(1);
      total       <= {(loReg[LO_W] ? hiWithCarry : hiNoCarry), loReg[LO_W-1:0]};
    end
  end

endmodule

// File: rtl/csa_fir_datapath.sv
module csa_fir_datapath
  import csa_fir_pkg::*;
#(
  parameter int TAPS     = 14,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 20,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  fir_ctrl_t           strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [IDX_W-1:0]    coefIdx,
  input  logic [COEF_W-1:0]   coefData,
  output logic [ACC_W-1:0]    result
);

  localparam int NDIG = SAMPLE_W / 2;

  logic [SAMPLE_W-1:0]    sampleReg;
  logic [SAMPLE_W:0]      sampleExt;
  booth_dig_t [NDIG-1:0]  boothVec;
  logic [ACC_W-1:0]       chainSum   [TAPS+1];
  logic [ACC_W-1:0]       chainCarry [TAPS+1];

  // Broadcast register; an empty cycle becomes a zero sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleReg <= '0;
    else       sampleReg <= strobes.sampleTake ? sampleIn : '0;
  end

  // Shared radix-4 recoding
  assign sampleExt = {sampleReg, 1'b0};
  for (genvar d = 0; d < NDIG; d++) begin : g_booth
    logic [2:0] trip;
    assign trip             = sampleExt[2*d+2 -: 3];
    assign boothVec[d].neg  = trip[2] & ~(trip[1] & trip[0]);
    assign boothVec[d].one  = trip[1] ^ trip[0];
    assign boothVec[d].two  = (trip[2] & ~trip[1] & ~trip[0]) |
                              (~trip[2] & trip[1] & trip[0]);
  end

  assign chainSum[0]   = '0;
  assign chainCarry[0] = '0;

  // Head tap (j = 0) holds the highest coefficient index
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    logic tapWe;
    assign tapWe = strobes.coefLoad && (coefIdx == IDX_W'(TAPS-1-j));
    csa_fir_tap #(.COEF_W(COEF_W), .ACC_W(ACC_W), .NDIG(NDIG)) u_tap (
      .clk          (clk),
      .rstN         (rstN),
      .coefWe       (tapWe),
      .coefData     (coefData),
      .booth        (boothVec),
      .chainSumIn   (chainSum[j]),
      .chainCarryIn (chainCarry[j]),
      .chainSumOut  (chainSum[j+1]),
      .chainCarryOut(chainCarry[j+1])
    );
  end

  csa_fir_final_add #(.ACC_W(ACC_W)) u_add (
    .clk     (clk),
    .rstN    (rstN),
    .sumVec  (chainSum[TAPS]),
    .carryVec(chainCarry[TAPS]),
    .total   (result)
  );

endmodule

// File: rtl/csa_fir.sv
module csa_fir
  import csa_fir_pkg::*;
#(
  parameter int TAPS     = 14,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 20,
  localparam int IDX_W   = $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                coefWe,
  input  logic [IDX_W-1:0]    coefIdx,
  input  logic [COEF_W-1:0]   coefData,
  output logic                outValid,
  output logic [ACC_W-1:0]    result
);

  // broadcast + two multiplier stages + tap chain + two adder stages
  localparam int LAT = 1 + 2 + TAPS + 2;

  fir_ctrl_t strobes;

  csa_fir_ctrl #(.TAPS(TAPS), .LAT(LAT), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .coefWe  (coefWe),
    .coefIdx (coefIdx),
    .strobes (strobes),
    .outValid(outValid)
  );

  csa_fir_datapath #(
    .TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W),
    .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .sampleIn(sampleIn),
    .coefIdx (coefIdx),
    .coefData(coefData),
    .result  (result)
  );

endmodule

// File: rtl/csa_fir_chk.sv
module csa_fir_chk #(
  parameter int TAPS  = 14,
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] result
);

  localparam int LAT = TAPS + 5;

  int sinceRst;
  int inFlight;
  int idleRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= 0;
      inFlight <= 0;
      idleRun  <= 0;
    end else begin
      if (sinceRst < LAT) sinceRst <= sinceRst + 1;
      inFlight <= inFlight + (inValid ? 1 : 0) - (outValid ? 1 : 0);
      if (inValid)            idleRun <= 0;
      else if (idleRun < LAT) idleRun <= idleRun + 1;
    end
  end

  // R1: reset state seen at the first edge after release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 0) |-> (!outValid && result == '0));

  // R2: nothing emerges before the pipeline could have been filled
  p_quiet_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < LAT) |-> !outValid);

  // R2: every output valid is backed by an accepted sample
  p_backed_output_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight > 0));

  // R9: at most one pipeline depth of samples outstanding
  p_flight_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= LAT);

  // R8: a long idle stretch drains the chain to zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idleRun >= LAT) |-> (result == '0));

endmodule

bind csa_fir csa_fir_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .result  (result)
);

// File: tb/tb_csa_fir.sv
module tb_csa_fir;

  localparam int TAPS = 14;
  localparam int SW   = 8;
  localparam int CW   = 8;
  localparam int AW   = 20;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic          coefWe = 1'b0;
  logic [IW-1:0] coefIdx = '0;
  logic [CW-1:0] coefData = '0;
  logic          outValid;
  logic [AW-1:0] result;

  csa_fir dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleIn(sampleIn),
    .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .outValid(outValid), .result(result)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    val;
    int    due;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  int    edgeCnt = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 0;
  bit    started = 0;
  string curTag = "R1";
  int    xh[16];
  int    vh[16];
  int    ch[16][TAPS];
  int    coefM[TAPS];

  always @(posedge clk) edgeCnt++;

  function automatic int rb(int t);
    return ((t % 16) + 16) % 16;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, expv, edgeCnt);
    end
  endtask

  // Drive one cycle; the reference window is updated for this edge
  task automatic step(input bit v, input int x, input bit we, input int idx, input int d);
    int e, y, s;
    @(negedge clk);
    inValid  = v;
    sampleIn = x[SW-1:0];
    coefWe   = we;
    coefIdx  = idx[IW-1:0];
    coefData = d[CW-1:0];
    e = edgeCnt + 1;
    if (we && idx < TAPS) coefM[idx] = d;
    xh[rb(e)] = v ? x : 0;
    vh[rb(e)] = v ? 1 : 0;
    for (int k = 0; k < TAPS; k++) ch[rb(e)][k] = coefM[k];
    y = 0;
    for (int k = 0; k < TAPS; k++) begin
      s = rb(e - k);
      y += ch[s][k] * xh[s];
    end
    if (vh[rb(e - (TAPS-1))] != 0) expQ.push_back('{y, e + 5, curTag});
  endtask

  function automatic int rs8();
    return int'($urandom_range(255)) - 128;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (started && rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected output valid", 1, 0);
        end else begin
          exp_t it;
          int r;
          it = expQ.pop_front();
          r  = {{(32-AW){result[AW-1]}}, result};
          check(it.due == edgeCnt, "R2 output timing", edgeCnt, it.due);
          check(r == it.val, it.tag, r, it.val);
        end
      end else if (expQ.size() > 0 && expQ[0].due == edgeCnt) begin
        check(1'b0, "R2 missing output valid", 0, 1);
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      xh[i] = 0;
      vh[i] = 0;
      for (int k = 0; k < TAPS; k++) ch[i][k] = 0;
    end
    for (int k = 0; k < TAPS; k++) coefM[k] = 0;

    repeat (4) step(0, 0, 0, 0, 0);
    rstN = 1'b1;
    started = 1;
    step(0, 0, 0, 0, 0);
    // R1: reset state at the ports
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(result == '0, "R1 result after reset", int'(result), 0);

    // R1: coefficients start at zero
    curTag = "R1";
    for (int i = 0; i < 20; i++) step(1, rs8(), 0, 0, 0);

    // R5: load all coefficients while idle
    curTag = "R5";
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, rs8());

    // R3 / R9: gapless stream
    curTag = "R9";
    for (int i = 0; i < 60; i++) step(1, rs8(), 0, 0, 0);

    // R7: gaps with garbage on the sample bus
    curTag = "R7";
    for (int i = 0; i < 60; i++) step($urandom_range(1), rs8(), 0, 0, 0);

    // R4: extreme operands
    curTag = "R4";
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, -128);
    for (int i = 0; i < 30; i++) step(1, -128, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, (i % 2) ? 127 : -128, 0, 0, 0);
    for (int k = 0; k < TAPS; k++) step(1, -128, 1, k, 127);
    for (int i = 0; i < 20; i++) step(1, -128, 0, 0, 0);

    // R3 / R5: writes landing in the same cycle as samples
    curTag = "R5";
    for (int i = 0; i < 80; i++)
      step(1, rs8(), $urandom_range(1), $urandom_range(TAPS-1), rs8());

    // R3: random mix of gaps and writes
    curTag = "R3";
    for (int i = 0; i < 80; i++)
      step($urandom_range(1), rs8(), $urandom_range(1), $urandom_range(TAPS-1), rs8());

    // R6: out-of-range writes during a stream
    curTag = "R6";
    for (int i = 0; i < 60; i++)
      step(1, rs8(), 1, TAPS + $urandom_range(1), rs8());

    // R8: long idle stretch
    curTag = "R8";
    for (int i = 0; i < 30; i++) step(0, rs8(), 0, 0, 0);
    check(result == '0, "R8 result after idle", int'(result), 0);
    check(outValid == 1'b0, "R8 outValid after idle", int'(outValid), 0);

    // Drain and confirm every expected result came out (R2)
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0);
    check(expQ.size() == 0, "R2 pending results", expQ.size(), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", edgeCnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule